// File: doc/BRIEF.md
# Three-Mode Operand Shifter

This block shifts a 16-bit source operand by 0 to 15 bit positions. It sits in the execute stage of a 16-bit datapath. It receives the operand from the register read path, together with the six least significant bits of the current instruction word. Those six bits carry the shift count, a direction select and a fill select.

Three kinds of shift are supported:

- shift toward the most significant end, with zeros brought in;
- logical shift toward the least significant end, with zeros brought in;
- arithmetic shift toward the least significant end, with copies of the sign bit brought in.

The shifted value is meant to be written to the destination register. Alongside it the block raises a request telling the condition code logic to latch new flags from that value.

By default the result is registered, so it appears one cycle after the operation is offered. A parameter can remove that register for a pipeline that has slack in the same cycle. In the registered form, the output value is held between operations.

Top module: `shf_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation, `shf_res` is 0x0000 and both `shf_vld` and `cc_upd` are 0.
- R2: When the count field `ctl_bits[3:0]` is 0, the result equals the operand in every mode.
- R3: When `ctl_bits[4]` is 0, the result is the operand shifted toward bit 15 by the count, with zeros entering at bit 0. `ctl_bits[5]` has no effect on this.
- R4: When `ctl_bits[5:4]` is 2'b01, the result is the operand shifted toward bit 0 by the count, with zeros entering at bit 15.
- R5: When `ctl_bits[5:4]` is 2'b11, the result is the operand shifted toward bit 0 by the count, with copies of operand bit 15 entering at bit 15.
- R6: An arithmetic shift by 15 gives 0xFFFF when operand bit 15 is 1, and 0x0000 when it is 0.
- R7: With the output register present, an operation offered with `op_vld` high at one rising edge is presented at the next edge. At that point `shf_vld` and `cc_upd` are both 1 for one cycle per operation.
- R8: In a cycle with `op_vld` low, `shf_res` keeps its previous value and `cc_upd` is 0. Changes on `operand` and `ctl_bits` during that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_vld | input | 1 | Operation offered this cycle |
| operand | input | 16 | Source value to shift |
| ctl_bits | input | 6 | Instruction bits: [3:0] count, [4] direction (0 = toward bit 15), [5] sign fill for right shifts |
| shf_res | output | 16 | Shifted value |
| shf_vld | output | 1 | `shf_res` carries a new result |
| cc_upd | output | 1 | Request to the condition code logic to latch flags from `shf_res` |

## Verification
Two events can fall in the same clock edge:

- one operation's result leaves on `shf_res`;
- the next operation is captured.

This happens whenever operations are offered back to back.

The bench provokes this by driving `op_vld` high for runs of consecutive cycles. Inside each run, mode, count and operand change randomly from cycle to cycle. Runs are separated by idle cycles in which the operand and control bits are scrambled.

Each presented value is judged against the reference shift of the operation offered exactly one edge earlier. During idle cycles, the bench checks that the held value and a low flag request were not disturbed by the scrambled inputs.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int AMT_W_DEF  = 4;

    // encoding is {sign_fill, direction}
    typedef enum logic [1:0] {
        SHF_LEFT = 2'b00,
        SHF_RLOG = 2'b01,
        SHF_RARI = 2'b11
    } shf_mode_e;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
#(
    parameter int AMT_W = AMT_W_DEF,
    localparam int CTL_W = AMT_W + 2
) (
    input  logic [CTL_W-1:0] ctl,
    output logic [AMT_W-1:0] amt,
    output shf_mode_e        mode
);
    localparam int DIR_POS  = AMT_W;
    localparam int FILL_POS = AMT_W + 1;

    always_comb begin
        amt = ctl[AMT_W-1:0];
        if (!ctl[DIR_POS]) begin
            // sign fill is meaningless toward the high end
            mode = SHF_LEFT;
        end else if (ctl[FILL_POS]) begin
            mode = SHF_RARI;
        end else begin
            mode = SHF_RLOG;
        end
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int AMT_W  = AMT_W_DEF
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  shf_mode_e         mode,
    output logic [DATA_W-1:0] dout
);
    logic              go_left;
    logic              fill_bit;
    logic [DATA_W-1:0] din_rev;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] stg [AMT_W+1];
    logic [DATA_W-1:0] post_rev;

    assign go_left  = (mode == SHF_LEFT);
    assign fill_bit = (mode == SHF_RARI) & din[DATA_W-1];

    // a left shift is a right shift of the mirrored word
    for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
        assign din_rev[b]  = din[DATA_W-1-b];
        assign post_rev[b] = stg[AMT_W][DATA_W-1-b];
    end

    assign pre    = go_left ? din_rev : din;
    assign stg[0] = pre;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = amt[s]
            ? {{STEP{fill_bit}}, stg[s][DATA_W-1:STEP]}
            : stg[s];
    end

    assign dout = go_left ? post_rev : stg[AMT_W];
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W  = DATA_W_DEF,
    parameter int AMT_W   = AMT_W_DEF,
    parameter bit OUT_REG = 1'b1,
    localparam int CTL_W  = AMT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_vld,
    input  logic [DATA_W-1:0] operand,
    input  logic [CTL_W-1:0]  ctl_bits,
    output logic [DATA_W-1:0] shf_res,
    output logic              shf_vld,
    output logic              cc_upd
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
        logic              cc;
    } out_s;

    logic [AMT_W-1:0]  amt;
    shf_mode_e         mode;
    logic [DATA_W-1:0] shifted;
    out_s              out_d;
    out_s              out_q;

    shf_decode #(.AMT_W(AMT_W)) dec_i (
        .ctl  (ctl_bits),
        .amt  (amt),
        .mode (mode)
    );

    shf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) core_i (
        .din  (operand),
        .amt  (amt),
        .mode (mode),
        .dout (shifted)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        out_d.cc  = 1'b0;
        if (op_vld) begin
            out_d.res = shifted;
            out_d.vld = 1'b1;
            out_d.cc  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    if (OUT_REG) begin : g_reg_out
        assign shf_res = out_q.res;
        assign shf_vld = out_q.vld;
        assign cc_upd  = out_q.cc;
    end else begin : g_comb_out
        assign shf_res = out_d.res;
        assign shf_vld = out_d.vld;
        assign cc_upd  = out_d.cc;
    end
endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DATA_W  = 16,
    parameter int AMT_W   = 4,
    parameter bit OUT_REG = 1'b1,
    localparam int CTL_W  = AMT_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_vld,
    input logic [DATA_W-1:0] operand,
    input logic [CTL_W-1:0]  ctl_bits,
    input logic [DATA_W-1:0] shf_res,
    input logic              shf_vld,
    input logic              cc_upd
);
    if (OUT_REG) begin : g_chk
        assert_reset_idle_R1: assert property (@(posedge clk)
            !rst_n |=> (shf_res == '0) && !shf_vld && !cc_upd);

        assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
            op_vld && (ctl_bits[AMT_W-1:0] == '0) |=> shf_res == $past(operand));

        assert_left_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            op_vld && !ctl_bits[AMT_W] && (ctl_bits[AMT_W-1:0] != '0) |=> !shf_res[0]);

        assert_logic_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            op_vld && (ctl_bits[AMT_W+1:AMT_W] == 2'b01) && (ctl_bits[AMT_W-1:0] != '0)
            |=> !shf_res[DATA_W-1]);

        assert_arith_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            op_vld && (ctl_bits[AMT_W+1:AMT_W] == 2'b11) |=> shf_res[DATA_W-1] == $past(operand[DATA_W-1]));

        assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            op_vld |=> shf_vld && cc_upd);

        assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !op_vld |=> $stable(shf_res) && !cc_upd);
    end
endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W), .OUT_REG(OUT_REG)) chk_i (.*);

// File: tb/shf_unit_tb.sv
module shf_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [15:0] operand = '0;
    logic [5:0]  ctl_bits = '0;
    logic [15:0] shf_res;
    logic        shf_vld;
    logic        cc_upd;

    int checks = 0;
    int errors = 0;
    logic [15:0] held;

    always #2 clk = ~clk;

    shf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .operand(operand),
        .ctl_bits(ctl_bits), .shf_res(shf_res), .shf_vld(shf_vld), .cc_upd(cc_upd)
    );

    function automatic logic [15:0] ref_shift(input logic [15:0] v, input logic [5:0] c);
        logic [15:0] r;
        r = v;
        for (int i = 0; i < int'(c[3:0]); i++) begin
            if (!c[4])      r = {r[14:0], 1'b0};
            else if (c[5])  r = {v[15], r[15:1]};
            else            r = {1'b0, r[15:1]};
        end
        return r;
    endfunction

    function automatic string req_of(input logic [5:0] c);
        if (c[3:0] == 4'd0) return "R2";
        if (!c[4])          return "R3";
        if (c[5] && c[3:0] == 4'hF) return "R6";
        if (c[5])           return "R5";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // offer one operation, then check it one edge later (R7)
    task automatic do_op(input logic [15:0] v, input logic [5:0] c);
        @(negedge clk);
        op_vld = 1'b1; operand = v; ctl_bits = c;
        @(posedge clk); #1;
        check(req_of(c), shf_res, ref_shift(v, c));
        check("R7", {15'd0, shf_vld & cc_upd}, 16'd1);
        held = shf_res;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        op_vld = 1'b0; operand = 16'($urandom); ctl_bits = 6'($urandom);
        @(posedge clk); #1;
        check("R8", shf_res, held);
        check("R8", {15'd0, cc_upd}, 16'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check("R1", shf_res, 16'h0000);
        check("R1", {14'd0, shf_vld, cc_upd}, 16'd0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", {shf_res[15:2], shf_vld, cc_upd}, 16'd0);
        held = shf_res;

        // directed corners
        do_op(16'hA5C3, 6'b000000);   // R2 left, count 0
        do_op(16'h8001, 6'b010000);   // R2 logical right, count 0
        do_op(16'hF00F, 6'b110000);   // R2 arithmetic right, count 0
        do_op(16'h8000, 6'b111111);   // R6 -> FFFF
        do_op(16'h7FFF, 6'b111111);   // R6 -> 0000
        do_op(16'hFFFF, 6'b100100);   // R3 fill bit ignored on left
        do_op(16'hFFFF, 6'b000100);   // R3 same result
        do_op(16'h8000, 6'b011111);   // R4 -> 0001
        do_op(16'h8421, 6'b110011);   // R5
        idle_cycle();                 // R8
        idle_cycle();

        // random back-to-back runs with idle gaps
        for (int run = 0; run < 60; run++) begin
            int len;
            len = 1 + ($urandom % 6);
            for (int k = 0; k < len; k++) begin
                logic [5:0] c;
                c = 6'($urandom);
                if (($urandom % 8) == 0) c[3:0] = 4'd0;
                do_op(16'($urandom), c);
            end
            for (int g = 0; g < int'($urandom % 3); g++) idle_cycle();
        end

        @(negedge clk); op_vld = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule